// File: doc/BRIEF.md
# Paged Serial Configuration Memory Reader

This block is the read-out sequencer of a serial configuration memory. It fetches bytes from a synchronous storage port and shifts them, most significant bit first, onto one serial data pin at one bit per clock. Its job is to feed a stored bitstream to a programmable device.

A word counter and a bit counter track progress. Both are cleared while the combined reset/output-enable input is low. They advance only while chip enable is low and output enable is high. The paging inputs choose the address range. With paging on, a two-bit page number picks one of four equal, contiguous quarters of the array. With paging off, the whole array is read from address zero.

A cascade output lets several such memories be chained. It drops low once the last word of the range is reached, then tracks chip enable, and returns high when output enable is pulled low. A serial-mode input, when low, makes chip enable and the paging inputs irrelevant.

Top module: `cfgmem_reader`

## Requirements
- R1: While `rst_oe` is low, both counters clear at once, with no clock needed. `sdo_en` is low, `cas_n` is high, `mem_rd` is low, and `mem_addr` shows the start address of the selected range.
- R2: `sdo_en` is high exactly when `rst_oe` is high and the chip is enabled. The chip is enabled when `ce_n` is low or when `ser_mode` is low.
- R3: While `ser_mode` is high and `ce_n` is high, no counter moves and `mem_rd` stays low. `mem_addr` holds its value. After `ce_n` returns low, shifting resumes at the next bit of the same word.
- R4: In the first enabled cycle after reset, `mem_rd` is asserted with the start address. From the next cycle, `sdo` carries `rd_data[7]` down to `rd_data[0]`, one bit per cycle.
- R5: With `page_on` and `ser_mode` high, page p (0..3) covers words p*2^(AW-2) through (p+1)*2^(AW-2)-1. The two upper bits of `mem_addr` equal `page_idx`. Page 00 is the lowest quarter and page 11 the highest.
- R6: With paging off, the range runs from word 0 to word 2^AW-1.
- R7: `mem_rd` is high for exactly one cycle, in the cycle where the last bit of a word is on `sdo`. In that cycle `mem_addr` carries the next word address. The storage returns that word on `rd_data` after the next clock edge.
- R8: At the last word of the range, the address saturates. No further reads are issued, and the last word is shifted out again.
- R9: `cas_n` goes low from the first bit of the last word of the range. After that it follows `ce_n` while `rst_oe` stays high. It goes high once `rst_oe` goes low, and stays high until the last word is reached again.
- R10: With `ser_mode` low, `ce_n`, `page_on` and `page_idx` have no effect. The full array is read from word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Low: asynchronous counter reset; high: output enable |
| page_on | input | 1 | Enables four-way page partitioning |
| page_idx | input | 2 | Page number when partitioning is on |
| ser_mode | input | 1 | Serial read mode; low ignores chip enable and paging |
| rd_data | input | 8 | Word returned by the storage port |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Data driver enable |
| cas_n | output | 1 | Cascade chip enable to the next device |
| mem_addr | output | AW | Word address to the storage port |
| mem_rd | output | 1 | Read strobe to the storage port |

## Verification
Each result falls due at a known cycle:
- `mem_rd` and `mem_addr` respond in the same cycle as the enable inputs.
- The first serial bit appears one clock edge after the priming read.
- Every later bit appears one edge after the previous one.
- `cas_n` and `sdo_en` change combinationally with `ce_n` and `rst_oe`. The one exception is the edge that moves the counter onto the last word, which clears `cas_n`.

The bench drives inputs and samples outputs on the falling clock edge. It steps through bit k of word n at exactly 1+8n+k falling edges after reset is released. It checks the combinational cascade and enable responses one time unit after the input change.

// File: rtl/cfgmem_reader.sv
module cfgmem_reader #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          ce_n,
  input  logic          rst_oe,
  input  logic          page_on,
  input  logic [1:0]    page_idx,
  input  logic          ser_mode,
  input  logic [7:0]    rd_data,
  output logic          sdo,
  output logic          sdo_en,
  output logic          cas_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd
);
  localparam int PW = AW - 2;

  logic [AW-1:0] off, off_d;
  logic [2:0]    bcnt;
  logic          primed, at_end;

  function automatic logic is_last(input logic [AW-1:0] v, input logic pg);
    return pg ? (&v[PW-1:0]) : (&v);
  endfunction

  function automatic logic [AW-1:0] map_addr(input logic [AW-1:0] v, input logic pg,
                                             input logic [1:0] sel);
    return pg ? {sel, v[PW-1:0]} : v;
  endfunction

  wire ce_act = ~ser_mode | ~ce_n;
  wire run    = rst_oe & ce_act;
  wire paging = page_on & ser_mode;
  wire step   = run & primed & (&bcnt) & ~is_last(off, paging);

  assign off_d    = step ? off + AW'(1) : off;
  assign mem_rd   = run & (~primed | step);
  assign mem_addr = map_addr(off_d, paging, page_idx);
  assign sdo      = rd_data[~bcnt];
  assign sdo_en   = run;
  assign cas_n    = at_end ? ~ce_act : 1'b1;

  always_ff @(posedge clk or negedge rst_oe) begin
    if (!rst_oe) begin
      off    <= '0;
      bcnt   <= '0;
      primed <= 1'b0;
      at_end <= 1'b0;
    end else if (run) begin
      primed <= 1'b1;
      if (primed) bcnt <= bcnt + 3'd1;
      off    <= off_d;
      at_end <= is_last(off_d, paging);
    end
  end
endmodule

module cfgmem_reader_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_oe,
  input logic          ce_n,
  input logic          ser_mode,
  input logic          page_on,
  input logic [1:0]    page_idx,
  input logic          mem_rd,
  input logic [AW-1:0] mem_addr,
  input logic          cas_n
);
  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_oe)
    (ser_mode && ce_n && $past(ser_mode && ce_n) && $stable(page_idx) && $stable(page_on))
      |-> ($stable(mem_addr) && !mem_rd));

  // R9
  cascade_gate_chk: assert property (@(posedge clk) disable iff (!rst_oe)
    !cas_n |-> (!ce_n || !ser_mode));

  // R5
  page_window_chk: assert property (@(posedge clk) disable iff (!rst_oe)
    (page_on && ser_mode && mem_rd) |-> (mem_addr[AW-1 -: 2] == page_idx));

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_oe)
    mem_rd |=> !mem_rd);
endmodule

bind cfgmem_reader cfgmem_reader_chk #(.AW(AW)) chk_i (.*);

// File: tb/cfgmem_reader_test.sv
module cfgmem_reader_test;
  localparam int AW = 6;
  localparam int PG = 1 << (AW - 2);
  localparam int FULL = 1 << AW;

  logic clk = 0, ce_n = 1, rst_oe = 0, page_on = 0, ser_mode = 1;
  logic [1:0] page_idx = 0;
  logic [7:0] rd_data = 0;
  logic sdo, sdo_en, cas_n, mem_rd;
  logic [AW-1:0] mem_addr;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  cfgmem_reader #(.AW(AW)) uut (.*);

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29) + 91);
  endfunction

  always @(posedge clk) if (mem_rd) rd_data <= pat(int'(mem_addr));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      finish_run();
    end
  end

  task automatic stream(input int base, input int nw, input int nchk, input string tag);
    @(negedge clk) rst_oe = 0;
    @(negedge clk) rst_oe = 1;
    #1;
    chk("R4 prime strobe", mem_rd, 1);
    chk("R4 prime addr", mem_addr, base);
    for (int k = 0; k < nchk; k++)
      for (int j = 0; j < 8; j++) begin
        int w = (k < nw) ? k : nw - 1;
        logic [7:0] d = pat(base + w);
        bit nxt = (j == 7) && (k < nw - 1);
        @(negedge clk);
        chk((k >= nw) ? "R8 repeat bit" : {tag, " bit"}, sdo, d[7-j]);
        chk("R9 cascade", cas_n, (k >= nw - 1) ? 0 : 1);
        chk((k >= nw - 1) ? "R8 no read" : "R7 strobe", mem_rd, nxt);
        if (nxt) chk("R7 next addr", mem_addr, base + k + 1);
      end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 sdo_en", sdo_en, 0);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 mem_addr", mem_addr, 0);
  endtask

  task automatic t_full();
    ser_mode = 1; page_on = 0; ce_n = 0;
    stream(0, FULL, FULL + 1, "R6");
  endtask

  task automatic t_page(input int p);
    ser_mode = 1; page_on = 1; page_idx = 2'(p); ce_n = 0;
    stream(p * PG, PG, PG + 1, "R5");
  endtask

  task automatic t_cascade();
    t_page(3);
    @(negedge clk) ce_n = 1; #1;
    chk("R9 follows ce high", cas_n, 1);
    ce_n = 0; #1;
    chk("R9 follows ce low", cas_n, 0);
    rst_oe = 0; #1;
    chk("R9 released by oe", cas_n, 1);
    chk("R1 driver off", sdo_en, 0);
    chk("R1 addr to base", mem_addr, 3 * PG);
    @(negedge clk) rst_oe = 1; ce_n = 1; #1;
    chk("R9 stays high", cas_n, 1);
    ce_n = 0; #1;
    chk("R9 high until reread", cas_n, 1);
  endtask

  task automatic t_freeze();
    ser_mode = 1; page_on = 1; page_idx = 2'd1; ce_n = 0;
    stream(PG, PG, 2, "R3");
    ce_n = 1; #1;
    chk("R2 driver off", sdo_en, 0);
    chk("R3 no read", mem_rd, 0);
    repeat (3) @(negedge clk);
    chk("R3 addr held", mem_addr, PG + 1);
    chk("R3 bit held", sdo, pat(PG + 1) & 1);
    ce_n = 0; #1;
    chk("R2 driver on", sdo_en, 1);
    chk("R3 resume strobe", mem_rd, 1);
    chk("R3 resume addr", mem_addr, PG + 2);
    @(negedge clk);
    chk("R3 next word", sdo, pat(PG + 2) >> 7);
  endtask

  task automatic t_sermode();
    ser_mode = 0; ce_n = 1; page_on = 1; page_idx = 2'd2;
    stream(0, FULL, 3, "R10");
    chk("R10 driver on with ce high", sdo_en, 1);
  endtask

  initial begin
    t_reset();
    t_full();
    t_page(0);
    t_page(2);
    t_cascade();
    t_freeze();
    t_sermode();
    finish_run();
  end
endmodule